// File: doc/BRIEF.md
# 100BASE-TX Transmit Code-Group Chain

This block forms the digital transmit path of a 100 Mb/s twisted-pair physical coding layer. It takes 4-bit nibbles from the MAC side and turns each one into a 5-bit code group. On its own it adds the start-of-stream pair J/K, the end-of-stream pair T/R, and idle fill between frames. It then shifts the code groups out one bit per clock, at 125 Mb/s, with the most significant code bit first. Each serial bit is XORed with a running key from an 11-bit linear feedback shift register. The register's starting value comes from the device's 5-bit PHY address, so every device on a board produces a different key sequence. A final stage converts the bit stream to NRZI.

Each of the three stages has its own bypass input, so a lab or test setup can look at the raw code groups, the unscrambled stream or the NRZ stream. The nibble input is a valid/ready stream paced by the serialiser. `in_ready` is high for one cycle in every five. A nibble is taken only in a cycle where both `in_valid` and `in_ready` are high. In any other cycle the input is not looked at.

Back-pressure is fixed by the line rate and cannot be stalled from the output side. A source that keeps a frame going must offer the next nibble in the very ready cycle that follows. If `in_valid` is low in a ready cycle during a frame, the frame ends there. The source has no way to hold the stream open. MLT-3 line coding and the analog driver are not part of this block.

Top module: `pcs_tx_chain`

## Requirements
- R1: After reset, `in_ready` is high in the first cycle and then in every fifth cycle, and low in all other cycles. With `bypass_enc` low, `in_ready` also stays low in the ready cycle that follows a T group, so the R group is never skipped.
- R2: A nibble taken during a frame becomes its data code group. Hex 0..F map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R3: The first nibble taken after idle is dropped and sent as J (11000). The second nibble is dropped and sent as K (10001). Data code groups begin with the third nibble.
- R4: A ready cycle with `in_valid` low during a frame sends T (01101). The next group is R (00111), and `in_valid` is ignored in that slot. After R, idle (11111) groups follow until a new frame starts.
- R5: Each code group is sent on `tx_bit` most significant bit first, one bit per clock. The first bit of the group chosen in ready cycle N appears two cycles after the clock edge that ends cycle N. With all bypasses set, `tx_bit` equals that bit.
- R6: The key comes from an 11-bit register s, which is loaded with {~phy_addr, phy_addr, 1} on every clock while `rst_n` is low. In each cycle the key is s[10]^s[8], and s shifts left with the key entering at bit 0. The register advances on every clock whatever the bypass settings are. The key is XORed with the serial bit.
- R7: The NRZI level is 0 after reset. It toggles on each scrambled 1 and holds on each scrambled 0, and `tx_bit` shows the level one cycle after the scrambled bit.
- R8: With `bypass_enc` high, each ready cycle sends {in_valid, in_data[3:0]} as the 5-bit group. No delimiters are added, and the block returns to idle framing.
- R9: With `bypass_scr` high, the serial bit passes through without the key.
- R10: With `bypass_nrzi` high, `tx_bit` is the scrambled bit delayed by one cycle.
- R11: During and just after reset, `tx_bit` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the scrambler seed |
| phy_addr | input | 5 | PHY address used to build the scrambler seed |
| bypass_enc | input | 1 | Pass the raw {valid, nibble} through instead of the code-group mapping |
| bypass_scr | input | 1 | Leave the serial stream unscrambled |
| bypass_nrzi | input | 1 | Output the NRZ stream instead of NRZI |
| in_valid | input | 1 | Nibble offered; also acts as transmit enable |
| in_ready | output | 1 | Slot pulse, one cycle in five |
| in_data | input | 4 | Nibble to transmit |
| tx_bit | output | 1 | Serial line bit |

## Verification
The assertions watch on every cycle that ready pulses never come back to back. They also check that an idle slot taking a valid nibble moves to the K step, that an R slot always returns to idle, that the key register never sticks at zero, and that each NRZI level change follows a scrambled 1. The exact code-group values, the key sequence for a given address, and the way the bypass settings combine can only be seen in the bench's scenarios. The bench compares every output bit against its own model under random framing, address and bypass patterns, and it decodes directed frames group by group.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;
  localparam int GRP_W = 5;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    ENC_IDLE  = 2'd0,
    ENC_KPEND = 2'd1,
    ENC_DATA  = 2'd2,
    ENC_RPEND = 2'd3
  } enc_st_e;

  localparam logic [GRP_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [GRP_W-1:0] CG_J    = 5'b11000;
  localparam logic [GRP_W-1:0] CG_K    = 5'b10001;
  localparam logic [GRP_W-1:0] CG_T    = 5'b01101;
  localparam logic [GRP_W-1:0] CG_R    = 5'b00111;

  // data nibble to code group (R2)
  function automatic logic [GRP_W-1:0] nib_to_group(input logic [NIB_W-1:0] n);
    logic [GRP_W-1:0] g;
    case (n)
      4'h0: g = 5'b11110;  4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;  4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;  4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;  4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;  4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;  4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;  4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;  default: g = 5'b11101;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/tx_group_encoder.sv
module tx_group_encoder
  import pcs_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NIB_W-1:0] in_data,
  output logic             ser_bit
);
  localparam int CNT_W = $clog2(GRP_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP_W - 1);

  logic [CNT_W-1:0] cnt;
  logic [GRP_W-1:0] sr;
  enc_st_e          st, nxt_st;
  logic [GRP_W-1:0] nxt_grp;
  logic             slot;

  assign slot     = (cnt == '0);
  assign in_ready = slot && (bypass || st != ENC_RPEND);
  assign ser_bit  = sr[GRP_W-1];

  always_comb begin
    nxt_st  = st;
    nxt_grp = CG_IDLE;
    if (bypass) begin
      nxt_st  = ENC_IDLE;
      nxt_grp = {in_valid, in_data};
    end else begin
      case (st)
        ENC_IDLE: begin
          nxt_grp = in_valid ? CG_J : CG_IDLE;
          nxt_st  = in_valid ? ENC_KPEND : ENC_IDLE;
        end
        ENC_KPEND: begin
          nxt_grp = in_valid ? CG_K : CG_T;
          nxt_st  = in_valid ? ENC_DATA : ENC_RPEND;
        end
        ENC_DATA: begin
          nxt_grp = in_valid ? nib_to_group(in_data) : CG_T;
          nxt_st  = in_valid ? ENC_DATA : ENC_RPEND;
        end
        default: begin
          nxt_grp = CG_R;
          nxt_st  = ENC_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      st  <= ENC_IDLE;
      sr  <= CG_IDLE;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (slot) begin
        sr <= nxt_grp;
        st <= nxt_st;
      end else begin
        sr <= {sr[GRP_W-2:0], 1'b0};
      end
    end
  end

  // R1
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R3
  jk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && !bypass && st == ENC_IDLE && in_valid) |=> (st == ENC_KPEND));

  // R4
  r_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && !bypass && st == ENC_RPEND) |=> (st == ENC_IDLE));
endmodule

// File: rtl/tx_scrambler.sv
module tx_scrambler #(
  parameter int LFSR_W = 11,
  parameter int TAP    = 9,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] seed_addr,
  input  logic              bypass,
  input  logic              din,
  output logic              dout
);
  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] seed;
  logic              key;

  // seed: bit 0 is 1, then the address, then its complement, repeating
  assign seed[0] = 1'b1;
  for (genvar i = 1; i < LFSR_W; i++) begin : g_seed
    if ((((i - 1) / ADDR_W) % 2) == 0) begin : g_true
      assign seed[i] = seed_addr[(i - 1) % ADDR_W];
    end else begin : g_inv
      assign seed[i] = ~seed_addr[(i - 1) % ADDR_W];
    end
  end

  assign key  = lfsr[LFSR_W-1] ^ lfsr[TAP-1];
  assign dout = bypass ? din : (din ^ key);

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= seed;
    else        lfsr <= {lfsr[LFSR_W-2:0], key};
  end

  // R6
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

// File: rtl/tx_nrzi.sv
module tx_nrzi (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic din,
  output logic dout
);
  logic lvl;
  logic raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl   <= 1'b0;
      raw_q <= 1'b0;
    end else begin
      lvl   <= lvl ^ din;
      raw_q <= din;
    end
  end

  assign dout = bypass ? raw_q : lvl;

  // R7
  nrzi_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && lvl != $past(lvl)) |-> $past(din));
endmodule

// File: rtl/pcs_tx_chain.sv
module pcs_tx_chain
  import pcs_tx_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LFSR_W = 11,
  parameter int TAP    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              bypass_enc,
  input  logic              bypass_scr,
  input  logic              bypass_nrzi,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NIB_W-1:0]  in_data,
  output logic              tx_bit
);
  logic nrz_bit;
  logic scr_bit;

  tx_group_encoder u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .bypass   (bypass_enc),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .ser_bit  (nrz_bit)
  );

  tx_scrambler #(.LFSR_W(LFSR_W), .TAP(TAP), .ADDR_W(ADDR_W)) u_scr (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_addr (phy_addr),
    .bypass    (bypass_scr),
    .din       (nrz_bit),
    .dout      (scr_bit)
  );

  tx_nrzi u_nrzi (
    .clk    (clk),
    .rst_n  (rst_n),
    .bypass (bypass_nrzi),
    .din    (scr_bit),
    .dout   (tx_bit)
  );
endmodule

// File: tb/pcs_tx_chain_test.sv
`timescale 1ns/1ps
module pcs_tx_chain_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] phy_addr = 5'h00;
  logic       bypass_enc = 1'b0, bypass_scr = 1'b0, bypass_nrzi = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_data = 4'h0;
  logic       in_ready, tx_bit;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state, as expected just after the latest edge
  int         m_cnt;
  int         m_st;      // 0 idle, 1 K next, 2 data, 3 R next
  logic [4:0] m_grp;
  logic [10:0] m_key;
  logic       m_lvl, m_raw;
  logic [9:0] cap;
  bit         infr;

  always #2.5 clk = ~clk;

  pcs_tx_chain uut (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr),
    .bypass_enc(bypass_enc), .bypass_scr(bypass_scr), .bypass_nrzi(bypass_nrzi),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .tx_bit(tx_bit)
  );

  function automatic logic [4:0] data_code(input logic [3:0] n);
    logic [4:0] t [16];
    t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
          5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
          5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_st = 0; m_grp = 5'b11111;
    m_key = {~phy_addr, phy_addr, 1'b1};
    m_lvl = 0; m_raw = 0;
  endtask

  // next-edge model built from R1..R10
  task automatic model_step();
    logic k, sb;
    if (!rst_n) begin model_reset(); return; end
    k  = m_key[10] ^ m_key[8];
    sb = m_grp[4] ^ (bypass_scr ? 1'b0 : k);
    m_raw = sb;
    m_lvl = m_lvl ^ sb;
    m_key = {m_key[9:0], k};
    if (m_cnt == 0) begin
      if (bypass_enc) begin m_grp = {in_valid, in_data}; m_st = 0; end
      else case (m_st)
        0: begin m_grp = in_valid ? 5'b11000 : 5'b11111; m_st = in_valid ? 1 : 0; end
        1: begin m_grp = in_valid ? 5'b10001 : 5'b01101; m_st = in_valid ? 2 : 3; end
        2: begin m_grp = in_valid ? data_code(in_data) : 5'b01101; m_st = in_valid ? 2 : 3; end
        default: begin m_grp = 5'b00111; m_st = 0; end
      endcase
    end else m_grp = {m_grp[3:0], 1'b0};
    m_cnt = (m_cnt == 4) ? 0 : m_cnt + 1;
  endtask

  task automatic tick();
    bit er;
    model_step();
    @(posedge clk);
    @(negedge clk);
    er = (m_cnt == 0) && (bypass_enc || m_st != 3);
    chk(in_ready === er, "R1 in_ready", in_ready, er);
    chk(tx_bit === (bypass_nrzi ? m_raw : m_lvl), "R5/R6/R7/R9/R10 tx_bit",
        tx_bit, bypass_nrzi ? m_raw : m_lvl);
    cap = {cap[8:0], tx_bit};
  endtask

  // one 5-cycle slot; returns the group finished by the previous slot and the ready seen
  task automatic slot(input bit v, input logic [3:0] d, output logic [4:0] prev, output bit rdy);
    rdy = in_ready;
    in_valid = v; in_data = d;
    tick();
    prev = cap[4:0];
    for (int i = 0; i < 4; i++) tick();
  endtask

  task automatic do_reset(input logic [4:0] a);
    phy_addr = a; rst_n = 0; in_valid = 0;
    repeat (3) tick();
    rst_n = 1;
    // R11
    chk(tx_bit === 1'b0, "R11 tx_bit after reset", tx_bit, 0);
    chk(in_ready === 1'b1, "R11 in_ready after reset", in_ready, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] g;
    bit r;
    void'($urandom(32'd4242));
    @(negedge clk);
    // directed framing with scrambler and NRZI bypassed
    bypass_scr = 1; bypass_nrzi = 1;
    do_reset(5'h0A);
    slot(0, 4'h0, g, r);
    slot(1, 4'h5, g, r);
    chk(g === 5'b11111, "R4 idle before frame", g, 5'b11111);
    slot(1, 4'h5, g, r);
    chk(g === 5'b11000, "R3 J group", g, 5'b11000);
    slot(1, 4'hA, g, r);
    chk(g === 5'b10001, "R3 K group", g, 5'b10001);
    slot(1, 4'h3, g, r);
    chk(g === 5'b10110, "R2 data A", g, 5'b10110);
    slot(0, 4'h0, g, r);
    chk(g === 5'b10101, "R2 data 3", g, 5'b10101);
    slot(1, 4'h7, g, r);
    chk(g === 5'b01101, "R4 T group", g, 5'b01101);
    chk(r === 1'b0, "R1 no ready in R slot", r, 0);
    slot(0, 4'h0, g, r);
    chk(g === 5'b00111, "R4 R group", g, 5'b00111);
    slot(0, 4'h0, g, r);
    chk(g === 5'b11111, "R4 valid ignored in R slot", g, 5'b11111);
    // all sixteen data codes
    slot(1, 4'h0, g, r); slot(1, 4'h0, g, r);
    for (int n = 0; n < 16; n++) begin
      slot(1, 4'(n), g, r);
      if (n >= 2) chk(g === data_code(4'(n - 1)), "R2 data table", g, data_code(4'(n - 1)));
    end
    slot(0, 4'h0, g, r);
    chk(g === data_code(4'hF), "R2 data F", g, data_code(4'hF));
    slot(0, 4'h0, g, r); slot(0, 4'h0, g, r);
    // R8 raw groups
    bypass_enc = 1;
    slot(1, 4'h6, g, r);
    slot(0, 4'h9, g, r);
    chk(g === 5'b10110, "R8 raw valid group", g, 5'b10110);
    slot(0, 4'h0, g, r);
    chk(g === 5'b01001, "R8 raw invalid group", g, 5'b01001);
    bypass_enc = 0;

    // random framing against the model, several addresses and bypass mixes
    for (int ph = 0; ph < 8; ph++) begin
      do_reset(5'($urandom));
      infr = 0;
      for (int c = 0; c < 2500; c++) begin
        if (c % 250 == 0) begin
          bypass_enc  = (ph == 1) || (ph >= 5 && $urandom % 4 == 0);
          bypass_scr  = (ph == 2) || (ph >= 5 && $urandom % 3 == 0);
          bypass_nrzi = (ph == 3) || (ph >= 5 && $urandom % 3 == 0);
        end
        if (m_cnt == 0) begin
          infr = infr ? ($urandom % 8 != 0) : ($urandom % 3 == 0);
          in_valid = infr;
        end else in_valid = $urandom % 2;
        in_data = 4'($urandom);
        tick();
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule